// File: doc/BRIEF.md
# BCD Time and Calendar Counter with Freeze Handshake

This block keeps wall-clock time and a calendar date as packed BCD in two 32-bit words. It advances by one second on every cycle in which the `tick_1hz` strobe is high. Seconds roll into minutes, minutes into hours, and hours into the date. The date rolls into the month, the month into the year, and the year into the century. Month lengths and leap years are applied. The day of week steps together with the date.

Software reaches the block through a small word-addressed register bus. Word 0 is control, word 1 is time, word 2 is calendar, word 3 is status and word 4 clears status. To set the clock, software raises one or both freeze-request bits in control. It then waits for the acknowledge flag in status, which the block raises on the next second strobe. Only after that acknowledge does the block accept writes to the time and calendar words. When software clears the request bits, counting resumes from the values it wrote. Status also carries sticky flags for second, minute and day events.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the time word reads 0 (00:00:00). The calendar reads century 0x20, year 0x00, month 0x01, day-of-week 1 and date 0x01. Control and status both read 0.
- R2: Time word layout is seconds [6:0], minutes [14:8] and hours [21:16], in BCD, and bit 22 always reads 0. When control bit 0 is clear, each tick advances seconds. 59 wraps to 00 and carries to minutes, minutes wrap the same way into hours, and hour 23 wraps to 00 and carries into the date.
- R3: While control bit 0 (time freeze request) is 1, ticks leave the time word unchanged.
- R4: Status bit 0 (acknowledge) is set by the first tick after a control request bit becomes 1 for a domain that has not yet been granted. It never rises without a tick, and it stays set until it is cleared.
- R5: A write to word 1 (time) takes effect when control bit 0 is set and that request has been acknowledged. A write to word 2 (calendar) takes effect when control bit 1 is set and that request has been acknowledged.
- R6: A time or calendar write is ignored while its domain is counting, and also after a request but before the acknowledging tick.
- R7: Once both request bits are cleared, counting resumes from the loaded values.
- R8: Calendar word layout is century [6:0], year [15:8], month [20:16] (1 to 12), day of week [23:21] (1 to 7) and date [29:24], in BCD. The date wraps after 28, 29, 30 or 31 as the month requires. A year is leap when it is divisible by 4. Year 00 is leap only when the century is divisible by 4. Month 12 wraps to 01 and carries to year, year 99 wraps to 00 and carries to century, and day of week goes from 7 back to 1.
- R9: While control bit 1 (calendar freeze request) is 1, the calendar word does not change, and a midnight carry from the time counter is dropped.
- R10: Each tick sets status bit 2. Each minute rollover sets bit 3. Each advance of the calendar date sets bit 4. Bit 1 always reads 0.
- R11: Writing word 4 clears each status bit whose write-data bit is 1, and leaves a bit unchanged where the data bit is 0. A set event in the same cycle wins over the clear.
- R12: Read data is registered: `bus_rdata` shows the word selected by `bus_addr` in the previous cycle. Control reads back its two request bits in [1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-second strobe, one second per high cycle |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | ADDR_W | Word address (0 control, 1 time, 2 calendar, 3 status, 4 status clear) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data for the previous cycle's address |

## Verification
The hardest situations to reach are the month-end and year-end wraps, because at one tick per second a single day takes 86400 ticks. The bench repeatedly uses the freeze handshake to load 23:59:59 with only time frozen, and then releases it with one tick. This forces a midnight carry every dozen cycles while the calendar keeps its own state, so whole years are walked date by date against an arithmetic leap-year model: 1900, 2000, 2023, 2024 and the 2099 to 2100 century carry. One full day is also swept tick by tick with the tick held high, so every second of the time word is compared.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [5:0] hr;
    logic [6:0] mn;
    logic [6:0] sc;
  } rtc_hms_t;

  typedef struct packed {
    logic [6:0] cent;
    logic [7:0] yr;
    logic [4:0] mon;
    logic [2:0] dow;
    logic [5:0] date;
  } rtc_cal_t;

  localparam int REG_CTRL = 0;
  localparam int REG_TIME = 1;
  localparam int REG_CAL  = 2;
  localparam int REG_STS  = 3;
  localparam int REG_CLR  = 4;

  localparam int ST_ACK = 0;
  localparam int ST_SEC = 2;
  localparam int ST_MIN = 3;
  localparam int ST_DAY = 4;
  localparam int ST_W   = 5;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] bcd_to_bin(input logic [7:0] v);
    return ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
  endfunction

  function automatic logic [5:0] last_date(input logic [7:0] mon,
                                           input logic [7:0] yr,
                                           input logic [7:0] cent);
    logic [7:0] yb;
    logic [7:0] cb;
    logic       leap;
    yb   = bcd_to_bin(yr);
    cb   = bcd_to_bin(cent);
    leap = (yr == 8'h00) ? (cb[1:0] == 2'b00) : (yb[1:0] == 2'b00);
    case (mon)
      8'h02:                      return leap ? 6'h29 : 6'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_upd_hs.sv
module rtc_upd_hs
  import rtc_pkg::*;
#(
  parameter int N_DOM = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [N_DOM-1:0] req,
  output logic [N_DOM-1:0] grant,
  output logic             ack_set
);

  logic [N_DOM-1:0] grant_q;

  for (genvar i = 0; i < N_DOM; i++) begin : g_dom
    always_ff @(posedge clk) begin
      if (rst || !req[i]) grant_q[i] <= 1'b0;
      else if (tick)      grant_q[i] <= 1'b1;
    end

    // R5: a grant never outlives its request
    a_r5_grant_drops: assert property (@(posedge clk) disable iff (rst)
      !req[i] |=> !grant_q[i]);
  end

  assign grant   = grant_q;
  assign ack_set = tick && |(req & ~grant_q);

endmodule

// File: rtl/rtc_time_cnt.sv
module rtc_time_cnt
  import rtc_pkg::*;
#(
  parameter logic [7:0] MS_LAST = 8'h59,
  parameter logic [7:0] HR_LAST = 8'h23
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     step,
  input  logic     ld,
  input  rtc_hms_t ld_val,
  output rtc_hms_t tq,
  output logic     min_roll,
  output logic     day_roll
);

  logic sc_wrap, mn_wrap, hr_wrap;

  assign sc_wrap  = ({1'b0, tq.sc} == MS_LAST);
  assign mn_wrap  = ({1'b0, tq.mn} == MS_LAST);
  assign hr_wrap  = ({2'b0, tq.hr} == HR_LAST);
  assign min_roll = step && !ld && sc_wrap;
  assign day_roll = min_roll && mn_wrap && hr_wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      tq <= '0;
    end else if (ld) begin
      tq <= ld_val;
    end else if (step) begin
      tq.sc <= sc_wrap ? '0 : 7'(bcd_inc({1'b0, tq.sc}));
      if (sc_wrap) tq.mn <= mn_wrap ? '0 : 7'(bcd_inc({1'b0, tq.mn}));
      if (sc_wrap && mn_wrap) tq.hr <= hr_wrap ? '0 : 6'(bcd_inc({2'b0, tq.hr}));
    end
  end

  // R2: seconds wrap to zero at the last value
  a_r2_sec_wrap: assert property (@(posedge clk) disable iff (rst)
    step && !ld && ({1'b0, tq.sc} == MS_LAST) |=> tq.sc == 7'h00);

endmodule

// File: rtl/rtc_cal_cnt.sv
module rtc_cal_cnt
  import rtc_pkg::*;
#(
  parameter logic [6:0] RST_CENT = 7'h20,
  parameter logic [7:0] RST_YR   = 8'h00,
  parameter logic [4:0] RST_MON  = 5'h01,
  parameter logic [2:0] RST_DOW  = 3'd1,
  parameter logic [5:0] RST_DATE = 6'h01
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     step,
  input  logic     ld,
  input  rtc_cal_t ld_val,
  output rtc_cal_t cq
);

  logic [5:0] dlast;
  logic       d_wrap, m_wrap, y_wrap;

  assign dlast  = last_date({3'b0, cq.mon}, cq.yr, {1'b0, cq.cent});
  assign d_wrap = (cq.date == dlast);
  assign m_wrap = (cq.mon == 5'h12);
  assign y_wrap = (cq.yr == 8'h99);

  always_ff @(posedge clk) begin
    if (rst) begin
      cq <= '{cent: RST_CENT, yr: RST_YR, mon: RST_MON, dow: RST_DOW, date: RST_DATE};
    end else if (ld) begin
      cq <= ld_val;
    end else if (step) begin
      cq.date <= d_wrap ? 6'h01 : 6'(bcd_inc({2'b0, cq.date}));
      cq.dow  <= (cq.dow == 3'd7) ? 3'd1 : cq.dow + 3'd1;
      if (d_wrap) cq.mon <= m_wrap ? 5'h01 : 5'(bcd_inc({3'b0, cq.mon}));
      if (d_wrap && m_wrap) cq.yr <= y_wrap ? 8'h00 : bcd_inc(cq.yr);
      if (d_wrap && m_wrap && y_wrap) cq.cent <= 7'(bcd_inc({1'b0, cq.cent}));
    end
  end

  // R8: the calendar moves only on a carry from the time counter or a load
  a_r8_hold_without_carry: assert property (@(posedge clk) disable iff (rst)
    !step && !ld |=> $stable(cq));

endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
  import rtc_pkg::*;
#(
  parameter int         ADDR_W   = 3,
  parameter int         DATA_W   = 32,
  parameter logic [6:0] RST_CENT = 7'h20,
  parameter logic [7:0] RST_YR   = 8'h00,
  parameter logic [4:0] RST_MON  = 5'h01,
  parameter logic [2:0] RST_DOW  = 3'd1,
  parameter logic [5:0] RST_DATE = 6'h01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1hz,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);

  localparam int N_DOM = 2;

  logic [N_DOM-1:0]  ctrl_q;
  logic [N_DOM-1:0]  grant;
  logic              ack_set;
  logic              wr_ctrl, wr_time, wr_cal, wr_clr;
  logic              ld_t, ld_c, step_t, step_c;
  logic              min_roll, day_roll;
  rtc_hms_t          tq, t_ld;
  rtc_cal_t          cq, c_ld;
  logic [ST_W-1:0]   sts_q, sts_set;
  logic [DATA_W-1:0] rd_mux, rdata_q;
  logic              unused_wdata_bits;

  assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(REG_CTRL));
  assign wr_time = bus_wr && (bus_addr == ADDR_W'(REG_TIME));
  assign wr_cal  = bus_wr && (bus_addr == ADDR_W'(REG_CAL));
  assign wr_clr  = bus_wr && (bus_addr == ADDR_W'(REG_CLR));

  assign unused_wdata_bits = ^{bus_wdata[DATA_W-1:30], bus_wdata[22], bus_wdata[7]};

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= bus_wdata[N_DOM-1:0];
  end

  rtc_upd_hs #(.N_DOM(N_DOM)) u_hs (
    .clk(clk), .rst(rst), .tick(tick_1hz), .req(ctrl_q),
    .grant(grant), .ack_set(ack_set)
  );

  assign ld_t   = wr_time && grant[0];
  assign ld_c   = wr_cal && grant[1];
  assign step_t = tick_1hz && !ctrl_q[0];
  assign step_c = day_roll && !ctrl_q[1];

  assign t_ld = '{hr: bus_wdata[21:16], mn: bus_wdata[14:8], sc: bus_wdata[6:0]};
  assign c_ld = '{cent: bus_wdata[6:0], yr: bus_wdata[15:8], mon: bus_wdata[20:16],
                  dow: bus_wdata[23:21], date: bus_wdata[29:24]};

  rtc_time_cnt u_time (
    .clk(clk), .rst(rst), .step(step_t), .ld(ld_t), .ld_val(t_ld),
    .tq(tq), .min_roll(min_roll), .day_roll(day_roll)
  );

  rtc_cal_cnt #(
    .RST_CENT(RST_CENT), .RST_YR(RST_YR), .RST_MON(RST_MON),
    .RST_DOW(RST_DOW), .RST_DATE(RST_DATE)
  ) u_cal (
    .clk(clk), .rst(rst), .step(step_c), .ld(ld_c), .ld_val(c_ld), .cq(cq)
  );

  always_comb begin
    sts_set         = '0;
    sts_set[ST_ACK] = ack_set;
    sts_set[ST_SEC] = tick_1hz;
    sts_set[ST_MIN] = min_roll;
    sts_set[ST_DAY] = step_c;
  end

  for (genvar i = 0; i < ST_W; i++) begin : g_sts
    always_ff @(posedge clk) begin
      if (rst) sts_q[i] <= 1'b0;
      else     sts_q[i] <= sts_set[i] | (sts_q[i] & ~(wr_clr & bus_wdata[i]));
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      ADDR_W'(REG_CTRL): rd_mux[N_DOM-1:0] = ctrl_q;
      ADDR_W'(REG_TIME): begin
        rd_mux[6:0]   = tq.sc;
        rd_mux[14:8]  = tq.mn;
        rd_mux[21:16] = tq.hr;
      end
      ADDR_W'(REG_CAL): begin
        rd_mux[6:0]   = cq.cent;
        rd_mux[15:8]  = cq.yr;
        rd_mux[20:16] = cq.mon;
        rd_mux[23:21] = cq.dow;
        rd_mux[29:24] = cq.date;
      end
      ADDR_W'(REG_STS): rd_mux[ST_W-1:0] = sts_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;

  // R4: acknowledge only rises on a second strobe
  a_r4_ack_on_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(sts_q[ST_ACK]) |-> $past(tick_1hz));

  // R3: frozen time holds unless loaded
  a_r3_time_frozen: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[0] && !ld_t |=> $stable(tq));

  // R6: an ungranted time write changes nothing
  a_r6_write_ignored: assert property (@(posedge clk) disable iff (rst)
    wr_time && !grant[0] && !tick_1hz |=> $stable(tq));

  // R9: frozen calendar holds unless loaded
  a_r9_cal_frozen: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[1] && !ld_c |=> $stable(cq));

  // R10: every strobe leaves the second event flag set
  a_r10_sec_event: assert property (@(posedge clk) disable iff (rst)
    tick_1hz |=> sts_q[ST_SEC]);

endmodule

// File: tb/rtc_bcd_calendar_test.sv
module rtc_bcd_calendar_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_1hz = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int y, mo, d, dw;

  always #2 clk = ~clk;

  rtc_bcd_calendar uut (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic logic [31:0] bcd(input int n);
    return 32'(((n / 10) << 4) | (n % 10));
  endfunction

  function automatic logic [31:0] pack_time(input int h, input int m, input int s);
    return bcd(s) | (bcd(m) << 8) | (bcd(h) << 16);
  endfunction

  function automatic logic [31:0] pack_cal(input int yy, input int mm, input int ww, input int dd);
    return bcd(yy / 100) | (bcd(yy % 100) << 8) | (bcd(mm) << 16)
         | (32'(ww) << 21) | (bcd(dd) << 24);
  endfunction

  function automatic int mdays(input int mm, input int yy);
    bit leap;
    leap = (yy % 4 == 0) && ((yy % 100 != 0) || (yy % 400 == 0));
    if (mm == 2) return leap ? 29 : 28;
    if (mm == 4 || mm == 6 || mm == 9 || mm == 11) return 30;
    return 31;
  endfunction

  task automatic adv_day();
    dw = (dw == 7) ? 1 : dw + 1;
    if (d == mdays(mo, y)) begin
      d = 1;
      if (mo == 12) begin mo = 1; y = y + 1; end
      else mo = mo + 1;
    end else d = d + 1;
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_w(input int a, input logic [31:0] v);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = v;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_r(input int a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = 3'(a);
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic tick1();
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
  endtask

  task automatic set_time(input logic [31:0] t);
    bus_w(0, 32'd1); tick1(); bus_w(1, t); bus_w(0, 32'd0);
  endtask

  task automatic set_both(input logic [31:0] t, input logic [31:0] c);
    bus_w(0, 32'd3); tick1(); bus_w(1, t); bus_w(2, c); bus_w(0, 32'd0);
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int years[5] = '{1900, 2000, 2023, 2024, 2099};

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    bus_r(0, v); chk("R1 ctrl", v, 32'h0);
    bus_r(1, v); chk("R1 time", v, 32'h0);
    bus_r(2, v); chk("R1 cal", v, pack_cal(2000, 1, 1, 1));
    bus_r(3, v); chk("R1 status", v, 32'h0);

    // R6 write while running is ignored
    bus_w(1, 32'h0012_3456);
    bus_r(1, v); chk("R6 running write", v, 32'h0);

    // R12 control readback; R6 write before acknowledge ignored
    bus_w(0, 32'd1);
    bus_r(0, v); chk("R12 ctrl readback", v, 32'h1);
    bus_w(1, 32'h0012_3456);
    bus_r(1, v); chk("R6 pre-ack write", v, 32'h0);
    bus_r(3, v); chk("R4 no ack before tick", v, 32'h0);
    tick1();
    bus_r(3, v); chk("R4 ack and R10 sec event", v, 32'h5);
    bus_r(1, v); chk("R3 frozen on ack tick", v, 32'h0);

    // R5 load after acknowledge, bit 22 dropped (R2)
    bus_w(1, pack_time(23, 59, 58) | 32'h0040_0000);
    bus_r(1, v); chk("R5 load time", v, pack_time(23, 59, 58));
    repeat (3) tick1();
    bus_r(1, v); chk("R3 frozen time", v, pack_time(23, 59, 58));

    // R11 status clear
    bus_w(4, 32'h1f);
    bus_r(3, v); chk("R11 clear all", v, 32'h0);
    tick1();
    bus_w(4, 32'h0);
    bus_r(3, v); chk("R11 zero clears nothing", v, 32'h4);
    bus_w(4, 32'h4);
    bus_r(3, v); chk("R11 clear sec", v, 32'h0);

    // R7 restart, R2 rollover into the date, R10 events
    bus_w(0, 32'd0);
    tick1();
    bus_r(1, v); chk("R7 resume", v, pack_time(23, 59, 59));
    bus_r(3, v); chk("R10 sec only", v, 32'h4);
    bus_w(4, 32'h1f);
    tick1();
    bus_r(1, v); chk("R2 midnight wrap", v, 32'h0);
    bus_r(2, v); chk("R8 date advance", v, pack_cal(2000, 1, 2, 2));
    bus_r(3, v); chk("R10 min and day events", v, 32'h1c);

    // R2 full day sweep, tick held high
    set_both(32'h0, pack_cal(2024, 2, 3, 28));
    @(negedge clk); bus_addr = 3'd1; tick_1hz = 1'b1;
    for (int k = 1; k <= 86400; k++) begin
      @(negedge clk);
      if (k == 86400) tick_1hz = 1'b0;
      chk("R2 sweep", bus_rdata,
          pack_time(((k - 1) / 3600) % 24, ((k - 1) / 60) % 60, (k - 1) % 60));
    end
    bus_r(1, v); chk("R2 day end", v, 32'h0);
    bus_r(2, v); chk("R8 leap Feb 29", v, pack_cal(2024, 2, 4, 29));

    // R8 whole-year date walks
    foreach (years[i]) begin
      y = years[i]; mo = 1; d = 1; dw = 1;
      set_both(pack_time(23, 59, 59), pack_cal(y, mo, dw, d));
      for (int n = 0; n < ((mdays(2, years[i]) == 29) ? 366 : 365); n++) begin
        set_time(pack_time(23, 59, 59));
        tick1();
        adv_day();
        bus_r(2, v); chk("R8 calendar walk", v, pack_cal(y, mo, dw, d));
      end
    end

    // R9 calendar frozen drops midnight carry; R6 pre-ack calendar write
    set_both(pack_time(23, 59, 59), pack_cal(2023, 12, 7, 31));
    bus_w(0, 32'd2);
    bus_w(2, pack_cal(2011, 5, 2, 5));
    bus_r(2, v); chk("R6 pre-ack cal write", v, pack_cal(2023, 12, 7, 31));
    tick1();
    bus_r(1, v); chk("R9 time runs", v, 32'h0);
    bus_r(2, v); chk("R9 cal frozen", v, pack_cal(2023, 12, 7, 31));
    bus_w(0, 32'd0);

    // R11 set wins over clear in the same cycle
    bus_w(4, 32'h1f);
    @(negedge clk);
    tick_1hz = 1'b1; bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = 32'h4;
    @(negedge clk);
    tick_1hz = 1'b0; bus_wr = 1'b0;
    bus_r(3, v); chk("R11 set beats clear", v & 32'h4, 32'h4);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule